// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Check

This block is the control sequencer of a small accumulator processor. Each instruction passes through a set of numbered phases. Those phases are next-address setup, instruction fetch, decode, operand address setup, operand read, execute and operand write. The sequencer leaves out any phase the instruction class does not need, and it may enter a phase a second time. After the last phase it always runs one interrupt check cycle. The block holds the program counter, the instruction register, the address register and the data buffer register, together with the accumulator. It reaches memory through a single-port request/response interface.

Every access to memory puts the address in the address register and moves data through the data buffer register. Requests use a valid/ready handshake. While `mem_req_valid` is high and `mem_req_ready` is low, the sequencer holds the address, the write flag and the write data stable. A write is complete in the cycle it is accepted. A read that is accepted returns exactly one response, with `mem_rsp_valid` high, in some later cycle. The sequencer always takes a response in the cycle it arrives, so the response path has no back-pressure.

A level-sensitive interrupt request is examined only in the check cycle. When it is taken, the sequencer saves the address of the next instruction and masks further requests. The next fetch then comes from `irq_vector`.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, `phase` is 0 and `mem_req_valid` is low. After reset the first fetch reads address 0, and interrupts start disabled, so an `irq` held high from reset is not taken.
- R2: The `phase` encoding is 0 next-address, 1 fetch, 2 decode, 3 operand address, 4 operand read, 5 execute, 6 operand write, 7 interrupt check and 8 parked. The phases that are used always appear in rising order, except for the repeat described in R4, and a check cycle (7) is followed by next-address (0).
- R3: The instruction word is {opcode[3:0], address field[11:0]}. The phase sequences per class are as follows:
  - NOP (0) runs 0,1,2,7.
  - LOAD (1) and ADD (2) run 0,1,2,3,4,5,7.
  - STORE (3) runs 0,1,2,3,6,7.
  - JUMP (4), RETI (5), EI (6) and LOADI (8) run 0,1,2,5,7.
  - Unused opcodes behave as NOP.
- R4: LOADN (9) is an indirect load. It runs 0,1,2,3,4,3,4,5,7: the first read fetches a pointer, and the operand address and operand read phases then run a second time using that pointer.
- R5: Each completed fetch advances the PC by one (by two when `BYTE_ADDR` is set). JUMP loads the PC from the address field instead.
- R6: A request that is not accepted stays valid with its address, write flag and data unchanged. A fetch response is always followed by decode in the next cycle.
- R7: In the check cycle, if `irq` is high and interrupts are enabled, the address of the next instruction is saved, interrupts are masked, and the next fetch comes from `irq_vector`.
- R8: A request raised while interrupts are masked stays pending and is taken at a later check cycle once interrupts are enabled again.
- R9: RETI restores the saved PC and re-enables interrupts, and EI only re-enables them. After either one, the check cycle of that same instruction never takes a request, so a pending request is taken at the end of the following instruction.
- R10: HALT (7) runs 0,1,2,8. It then stays in phase 8 with no memory request until reset.
- R11: LOAD sets ACC to mem[a], ADD adds mem[a] to ACC, LOADI sets ACC to the zero-extended field, and STORE writes ACC to address a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_vector | input | ADDR_W | Start address of the interrupt handler |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address (address register) |
| mem_req_wdata | output | DATA_W | Write data (data buffer register) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| phase | output | 4 | Current phase, encoded as in R2 |

## Verification
Next-address, decode, operand address, execute and check each take one cycle, so the new `phase` value shows one edge after the phase is entered. Fetch and operand read need at least two cycles: one to have the request accepted, then the response one cycle later in this bench's memory model. A write phase ends on the edge where it is accepted. The scoreboard does not assume fixed cycle counts. It samples on the falling edge and compares every change of `phase` against a queued expected sequence. It also compares every accepted fetch address and every accepted write against their own queues, so random stalls on `mem_req_ready` shift timing without affecting the checks. Interrupt timing is checked by the order of fetch addresses, with the request raised and dropped on observed fetches of the handler.

// File: rtl/icseq_pkg.sv
package icseq_pkg;
  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    PH_NXTADR = 4'd0,
    PH_FETCH  = 4'd1,
    PH_DECODE = 4'd2,
    PH_OPADR  = 4'd3,
    PH_OPRD   = 4'd4,
    PH_EXEC   = 4'd5,
    PH_OPWR   = 4'd6,
    PH_IRQCHK = 4'd7,
    PH_PARK   = 4'd8
  } phase_t;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OP_STORE = 4'd3;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd4;
  localparam logic [OP_W-1:0] OP_RETI  = 4'd5;
  localparam logic [OP_W-1:0] OP_EI    = 4'd6;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd7;
  localparam logic [OP_W-1:0] OP_LOADI = 4'd8;
  localparam logic [OP_W-1:0] OP_LOADN = 4'd9;

  typedef struct packed {
    logic needs_opadr;
    logic needs_exec;
    logic needs_wr;
    logic indirect;
    logic is_jump;
    logic is_reti;
    logic is_ei;
    logic is_halt;
    logic acc_load;
    logic acc_add;
    logic acc_imm;
  } dec_t;
endpackage

// File: rtl/icseq_decode.sv
module icseq_decode import icseq_pkg::*; (
  input  logic [OP_W-1:0] opcode,
  output dec_t            dec
);
  always_comb begin
    dec = '0;
    unique case (opcode)
      OP_LOAD:  begin dec.needs_opadr = 1'b1; dec.needs_exec = 1'b1; dec.acc_load = 1'b1; end
      OP_ADD:   begin dec.needs_opadr = 1'b1; dec.needs_exec = 1'b1; dec.acc_add = 1'b1; end
      OP_STORE: begin dec.needs_opadr = 1'b1; dec.needs_wr = 1'b1; end
      OP_JUMP:  begin dec.needs_exec = 1'b1; dec.is_jump = 1'b1; end
      OP_RETI:  begin dec.needs_exec = 1'b1; dec.is_reti = 1'b1; end
      OP_EI:    begin dec.needs_exec = 1'b1; dec.is_ei = 1'b1; end
      OP_HALT:  dec.is_halt = 1'b1;
      OP_LOADI: begin dec.needs_exec = 1'b1; dec.acc_imm = 1'b1; end
      OP_LOADN: begin
        dec.needs_opadr = 1'b1; dec.needs_exec = 1'b1;
        dec.indirect = 1'b1; dec.acc_load = 1'b1;
      end
      default:  dec = '0;
    endcase
  end
endmodule

// File: rtl/icseq_pc_ctl.sv
module icseq_pc_ctl #(
  parameter int ADDR_W  = 12,
  parameter int PC_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_done,
  input  logic              jump_ld,
  input  logic [ADDR_W-1:0] jump_tgt,
  input  logic              reti,
  input  logic              ei,
  input  logic              at_check,
  input  logic              irq,
  input  logic [ADDR_W-1:0] vector,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] epc;
  logic              ie;
  logic              just_en;
  logic              take;

  // a request is never taken in the check cycle of the instruction that enabled it
  assign take = at_check && irq && ie && !just_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      epc     <= '0;
      ie      <= 1'b0;
      just_en <= 1'b0;
    end else begin
      if (take) begin
        epc <= pc;
        pc  <= vector;
      end else if (reti) begin
        pc <= epc;
      end else if (jump_ld) begin
        pc <= jump_tgt;
      end else if (fetch_done) begin
        pc <= pc + STEP;
      end

      if (take)
        ie <= 1'b0;
      else if (reti || ei)
        ie <= 1'b1;

      if (reti || ei)
        just_en <= 1'b1;
      else if (at_check)
        just_en <= 1'b0;
    end
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq import icseq_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int BYTE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [3:0]        phase
);
  localparam int PC_STEP = (BYTE_ADDR != 0) ? 2 : 1;
  localparam int PAD_W   = DATA_W - ADDR_W;

  phase_t            ph;
  logic [DATA_W-1:0] ir, mbr, acc;
  logic [ADDR_W-1:0] mar, pc;
  logic              rd_wait, ind_second;
  dec_t              dec;
  logic              exec_cyc, fetch_done;

  icseq_decode u_dec (
    .opcode (ir[DATA_W-1 -: OP_W]),
    .dec    (dec)
  );

  assign exec_cyc   = (ph == PH_EXEC);
  assign fetch_done = (ph == PH_FETCH) && rd_wait && mem_rsp_valid;

  icseq_pc_ctl #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_done (fetch_done),
    .jump_ld    (exec_cyc && dec.is_jump),
    .jump_tgt   (ir[ADDR_W-1:0]),
    .reti       (exec_cyc && dec.is_reti),
    .ei         (exec_cyc && dec.is_ei),
    .at_check   (ph == PH_IRQCHK),
    .irq        (irq),
    .vector     (irq_vector),
    .pc         (pc)
  );

  assign mem_req_valid = (((ph == PH_FETCH) || (ph == PH_OPRD)) && !rd_wait) || (ph == PH_OPWR);
  assign mem_req_we    = (ph == PH_OPWR);
  assign mem_req_addr  = mar;
  assign mem_req_wdata = mbr;
  assign phase         = ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_NXTADR;
      ir         <= '0;
      mbr        <= '0;
      acc        <= '0;
      mar        <= '0;
      rd_wait    <= 1'b0;
      ind_second <= 1'b0;
    end else begin
      unique case (ph)
        PH_NXTADR: begin
          mar <= pc;
          ph  <= PH_FETCH;
        end
        PH_FETCH: begin
          if (!rd_wait) begin
            if (mem_req_ready) rd_wait <= 1'b1;
          end else if (mem_rsp_valid) begin
            ir      <= mem_rsp_data;
            mbr     <= mem_rsp_data;
            rd_wait <= 1'b0;
            ph      <= PH_DECODE;
          end
        end
        PH_DECODE: begin
          ind_second <= 1'b0;
          if (dec.is_halt)          ph <= PH_PARK;
          else if (dec.needs_opadr) ph <= PH_OPADR;
          else if (dec.needs_exec)  ph <= PH_EXEC;
          else                      ph <= PH_IRQCHK;
        end
        PH_OPADR: begin
          mar <= ind_second ? mbr[ADDR_W-1:0] : ir[ADDR_W-1:0];
          if (dec.needs_wr) begin
            mbr <= acc;
            ph  <= PH_OPWR;
          end else begin
            ph  <= PH_OPRD;
          end
        end
        PH_OPRD: begin
          if (!rd_wait) begin
            if (mem_req_ready) rd_wait <= 1'b1;
          end else if (mem_rsp_valid) begin
            mbr     <= mem_rsp_data;
            rd_wait <= 1'b0;
            if (dec.indirect && !ind_second) begin
              ind_second <= 1'b1;
              ph         <= PH_OPADR;
            end else begin
              ph         <= PH_EXEC;
            end
          end
        end
        PH_EXEC: begin
          if (dec.acc_load)     acc <= mbr;
          else if (dec.acc_add) acc <= acc + mbr;
          else if (dec.acc_imm) acc <= {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
          ph <= PH_IRQCHK;
        end
        PH_OPWR: begin
          if (mem_req_ready) ph <= PH_IRQCHK;
        end
        PH_IRQCHK: ph <= PH_NXTADR;
        PH_PARK:   ph <= PH_PARK;
        default:   ph <= PH_NXTADR;
      endcase
    end
  end
endmodule

// File: rtl/icseq_checker.sv
module icseq_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        phase,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R6
  fetch_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd1) && mem_rsp_valid |=> phase == 4'd2);

  // R2
  check_to_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd7 |=> phase == 4'd0);

  // R3
  decode_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd2 |=> (phase == 4'd3) || (phase == 4'd5) || (phase == 4'd7) || (phase == 4'd8));

  // R4
  oprd_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'd4) && mem_rsp_valid |=> (phase == 4'd3) || (phase == 4'd5));

  // R10
  park_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'd8 |=> phase == 4'd8 && !mem_req_valid);
endmodule

bind instr_cycle_seq icseq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase         (phase),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_instr_cycle_seq.sv
module test_instr_cycle_seq;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam logic [AW-1:0] VEC = 12'h040;

  localparam int C_NOP = 0, C_EXE = 1, C_RD = 2, C_ST = 3, C_IND = 4, C_HLT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq = 1'b0;
  logic          req_valid, req_we, req_ready, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_data;
  logic [3:0]    phase;

  always #2.5 clk = ~clk;

  instr_cycle_seq #(.DATA_W(DW), .ADDR_W(AW)) i_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_vector(VEC),
    .mem_req_valid(req_valid), .mem_req_ready(req_ready), .mem_req_we(req_we),
    .mem_req_addr(req_addr), .mem_req_wdata(req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data), .phase(phase)
  );

  int nchk = 0, nbad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one cycle read latency, optional stalls
  logic [DW-1:0] mem [256];
  logic          stall_mode = 1'b0;
  logic [7:0]    lfsr = 8'h5a;

  initial begin req_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0; end

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (req_we) mem[req_addr[7:0]] <= req_wdata;
      else begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[req_addr[7:0]];
      end
    end
  end

  // scoreboard queues
  logic [3:0]    exp_ph[$];
  string         ph_tag[$];
  logic [AW-1:0] exp_fa[$];
  string         fa_tag[$];
  logic [AW-1:0] exp_wa[$];
  logic [DW-1:0] exp_wd[$];

  function automatic logic [DW-1:0] mk(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic push_ph(input logic [3:0] p, input string t);
    exp_ph.push_back(p); ph_tag.push_back(t);
  endtask

  task automatic push_instr(input int cls, input logic [AW-1:0] fa, input string t);
    push_ph(4'd0, t); push_ph(4'd1, t); push_ph(4'd2, t);
    case (cls)
      C_NOP: push_ph(4'd7, "R3");
      C_EXE: begin push_ph(4'd5, t); push_ph(4'd7, t); end
      C_RD:  begin push_ph(4'd3, "R3"); push_ph(4'd4, "R3"); push_ph(4'd5, "R3"); push_ph(4'd7, "R3"); end
      C_ST:  begin push_ph(4'd3, "R3"); push_ph(4'd6, "R3"); push_ph(4'd7, "R3"); end
      C_IND: begin // R4 repeat of operand address and read
        push_ph(4'd3, "R4"); push_ph(4'd4, "R4"); push_ph(4'd3, "R4");
        push_ph(4'd4, "R4"); push_ph(4'd5, "R4"); push_ph(4'd7, "R4");
      end
      default: push_ph(4'd8, "R10");
    endcase
    exp_fa.push_back(fa); fa_tag.push_back(t);
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_wa.push_back(a); exp_wd.push_back(d);
  endtask

  // monitor: phase changes, fetches, writes, request hold, park quietness
  logic [3:0]    last_ph = 4'd0;
  bit            irq_run = 1'b0, reraised = 1'b0;
  bit            held = 1'b0;
  logic [AW-1:0] held_addr = '0;
  int            park_reqs = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      last_ph = 4'd0; held = 1'b0; park_reqs = 0;
    end else begin
      if (phase != last_ph) begin
        if (exp_ph.size() == 0) chk(1'b0, "R2", "unexpected phase", 32'(phase), 32'hx);
        else begin
          logic [3:0] e;
          string t;
          e = exp_ph.pop_front(); t = ph_tag.pop_front();
          chk(phase == e, t, "phase", 32'(phase), 32'(e));
        end
        last_ph = phase;
      end
      if (held) chk(req_valid && req_addr == held_addr, "R6", "held request", 32'(req_addr), 32'(held_addr));
      held = req_valid && !req_ready;
      held_addr = req_addr;
      if (phase == 4'd8 && req_valid) park_reqs++;
      if (req_valid && req_ready && !req_we && phase == 4'd1) begin
        if (exp_fa.size() == 0) chk(1'b0, "R10", "unexpected fetch", 32'(req_addr), 32'hx);
        else begin
          logic [AW-1:0] e;
          string t;
          e = exp_fa.pop_front(); t = fa_tag.pop_front();
          chk(req_addr == e, t, "fetch address", 32'(req_addr), 32'(e));
        end
        if (irq_run) begin
          if (req_addr == VEC) irq = 1'b0;
          if (req_addr == VEC + 12'd1 && !reraised) begin irq = 1'b1; reraised = 1'b1; end
        end
      end
      if (req_valid && req_ready && req_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "R11", "unexpected write", 32'(req_addr), 32'hx);
        else begin
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          chk(req_addr == ea, "R11", "write address", 32'(req_addr), 32'(ea));
          chk(req_wdata == ed, "R11", "write data", 32'(req_wdata), 32'(ed));
        end
      end
    end
  end

  task automatic do_reset(input logic irq_init);
    rst_n = 1'b0; irq = irq_init;
    repeat (3) @(negedge clk);
    chk(phase == 4'd0, "R1", "reset phase", 32'(phase), 32'd0);
    chk(!req_valid, "R1", "reset request", 32'(req_valid), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run(input string name);
    int n = 0;
    while (phase != 4'd8 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(1'b0, "WDOG", name, 32'(n), 32'd5000);
    repeat (40) @(negedge clk);
    chk(exp_ph.size() == 0, "R2", "phases left", 32'(exp_ph.size()), 32'd0);
    chk(exp_fa.size() == 0, "R5", "fetches left", 32'(exp_fa.size()), 32'd0);
    chk(exp_wa.size() == 0, "R11", "writes left", 32'(exp_wa.size()), 32'd0);
    chk(park_reqs == 0, "R10", "requests while parked", 32'(park_reqs), 32'd0);
  endtask

  initial begin
    // run A: all classes, no stalls, irq held high but never enabled (R1)
    foreach (mem[i]) mem[i] = '0;
    mem[0]  = mk(4'd8, 12'h005);          // LOADI 5
    mem[1]  = mk(4'd2, 12'h020);          // ADD [20] -> 8
    mem[2]  = mk(4'd3, 12'h021);          // STORE
    mem[3]  = mk(4'd9, 12'h022);          // LOADN [[22]]
    mem[4]  = mk(4'd3, 12'h024);          // STORE
    mem[5]  = mk(4'd4, 12'h008);          // JUMP 8
    mem[8]  = mk(4'd0, 12'h000);          // NOP
    mem[9]  = mk(4'd1, 12'h020);          // LOAD [20]
    mem[10] = mk(4'd3, 12'h025);          // STORE
    mem[11] = mk(4'd7, 12'h000);          // HALT
    mem[8'h20] = 16'h0003; mem[8'h22] = 16'h0023; mem[8'h23] = 16'h1234;
    push_instr(C_EXE, 12'h000, "R1");
    void'(exp_ph.pop_front()); void'(ph_tag.pop_front());
    push_instr(C_RD,  12'h001, "R5");
    push_instr(C_ST,  12'h002, "R5");
    push_instr(C_IND, 12'h003, "R4");
    push_instr(C_ST,  12'h004, "R5");
    push_instr(C_EXE, 12'h005, "R5");
    push_instr(C_NOP, 12'h008, "R5");     // R5 jump target
    push_instr(C_RD,  12'h009, "R1");
    push_instr(C_ST,  12'h00a, "R1");
    push_instr(C_HLT, 12'h00b, "R10");
    push_wr(12'h021, 16'h0008);
    push_wr(12'h024, 16'h1234);
    push_wr(12'h025, 16'h0003);
    stall_mode = 1'b0; irq_run = 1'b0;
    do_reset(1'b1);
    finish_run("run A");

    // run B: stalls, interrupts, masking and delayed re-enable
    foreach (mem[i]) mem[i] = '0;
    mem[0] = mk(4'd6, 12'h000);           // EI
    mem[1] = mk(4'd0, 12'h000);           // NOP, irq taken here
    mem[2] = mk(4'd8, 12'h009);           // LOADI 9
    mem[3] = mk(4'd3, 12'h031);           // STORE
    mem[4] = mk(4'd7, 12'h000);           // HALT
    mem[8'h40] = mk(4'd8, 12'h007);       // handler: LOADI 7
    mem[8'h41] = mk(4'd3, 12'h030);       // STORE
    mem[8'h42] = mk(4'd5, 12'h000);       // RETI
    push_instr(C_EXE, 12'h000, "R9");
    void'(exp_ph.pop_front()); void'(ph_tag.pop_front());
    push_instr(C_NOP, 12'h001, "R9");
    push_instr(C_EXE, 12'h040, "R7");
    push_instr(C_ST,  12'h041, "R7");
    push_instr(C_EXE, 12'h042, "R8");
    push_instr(C_EXE, 12'h002, "R9");     // not interrupted in RETI check cycle
    push_instr(C_EXE, 12'h040, "R8");     // pending request taken after one instruction
    push_instr(C_ST,  12'h041, "R8");
    push_instr(C_EXE, 12'h042, "R9");
    push_instr(C_ST,  12'h003, "R7");     // saved PC restored
    push_instr(C_HLT, 12'h004, "R10");
    push_wr(12'h030, 16'h0007);
    push_wr(12'h030, 16'h0007);
    push_wr(12'h031, 16'h0007);
    stall_mode = 1'b1; irq_run = 1'b1; reraised = 1'b0;
    do_reset(1'b1);
    finish_run("run B");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL WDOG global timeout actual=%0d expected=0", 150000);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule